// File: doc/BRIEF.md
# Parallel Camera Pixel Capture Interface

This block is the receiving end of a parallel image-sensor link. The sensor sends a pixel clock, a line-valid strobe, a frame-valid strobe and a data bus of up to 14 bits. The block takes all of these in on its own system clock and passes them through a synchronizer. It finds the chosen pixel-clock edge in the synchronized stream and keeps a sample only when both the line and the frame are active. It never drives any sensor line.

Kept samples are packed into 32-bit words. In 8-bit mode four samples make one word. In the wider modes two zero-extended samples make one word. Each finished word is placed in an output register and a request is raised. The consumer, usually a memory mover, takes the word and pulses an acknowledge. If a second word finishes before the first one was acknowledged, the new word replaces the old one and a sticky overrun flag is set.

Top module: `cam_capture_top`

## Requirements
- R1: While `cfg_en` is 0, no sample is kept and no new request is raised. Clearing `cfg_en` also clears the packing state and the overrun flag.
- R2: `cfg_width` selects the sample width: 00 = 8 bits, 01 = 10 bits, 10 = 12 bits, 11 = 14 bits. Data bits above the selected width are ignored and stored as zero.
- R3: In 8-bit mode four kept samples make one word. The first sample goes to bits [7:0], the second to [15:8], the third to [23:16] and the fourth to [31:24].
- R4: In the 10, 12 and 14-bit modes two kept samples make one word. Each sample is zero-extended into a 16-bit half, and the first sample goes to bits [15:0].
- R5: A sample is taken on the rising edge of `pix_clk` when `cfg_pclk_rise` is 1, and on the falling edge when it is 0.
- R6: A sample is kept only while the line sync is at its active level.
- R7: A sample is kept only while the frame sync is at its active level. Any partly filled word is dropped when the frame sync goes inactive, and packing restarts at the first slot in the next frame.
- R8: A sync is active when it equals its polarity bit: `cfg_hs_high` for the line sync and `cfg_vs_high` for the frame sync. The value 1 means active-high.
- R9: When the line sync and the frame sync change on the same pixel-clock edge, the sample on that edge is kept exactly once if both became active. It is not kept if both became inactive.
- R10: Each completed word raises `word_req`. `word_req` stays high until a cycle with `word_ack` high, and then drops unless another word completes in that same cycle.
- R11: If a word completes while `word_req` is high and `word_ack` is low, `word_q` takes the new word and `overrun` is set. `overrun` stays set until `cfg_en` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Capture enable |
| cfg_width | input | 2 | Sample width select |
| cfg_pclk_rise | input | 1 | 1 = sample on rising pixel-clock edge, 0 = falling |
| cfg_hs_high | input | 1 | Line sync active level |
| cfg_vs_high | input | 1 | Frame sync active level |
| pix_clk | input | 1 | Sensor pixel clock |
| pix_hs | input | 1 | Sensor line sync |
| pix_vs | input | 1 | Sensor frame sync |
| pix_d | input | 14 | Sensor data bus |
| word_q | output | 32 | Packed output word |
| word_req | output | 1 | Output word waiting to be taken |
| word_ack | input | 1 | Consumer took the word |
| overrun | output | 1 | Sticky flag: a word was overwritten before it was taken |

## Verification
The hardest case to reach is the overrun path. It needs two full words to be packed while the consumer holds back its acknowledge. Each word takes several pixel-clock periods at the synchronizer's pace. The bench turns off its automatic acknowledge, feeds eight 8-bit samples, and then checks that the second word is in the register, the flag is set and the request is still pending.

The next hardest case is both syncs switching on the same edge. The stimulus raises both syncs together on a data-carrying pixel and later drops both together. The scoreboard then shows whether that sample was counted exactly once.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;

  typedef enum logic [1:0] {
    PW_8  = 2'b00,
    PW_10 = 2'b01,
    PW_12 = 2'b10,
    PW_14 = 2'b11
  } pix_width_e;

  // Mask that keeps only the bits of the selected sample width.
  function automatic logic [15:0] width_mask(pix_width_e w);
    int unsigned nbits;
    nbits = 8 + 2 * int'(w);
    return 16'((32'd1 << nbits) - 32'd1);
  endfunction

endpackage

// File: rtl/cam_pin_sync.sv
module cam_pin_sync #(
  parameter int DATA_W = 14,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_pclk_rise,
  input  logic              pix_clk,
  input  logic              pix_hs,
  input  logic              pix_vs,
  input  logic [DATA_W-1:0] pix_d,
  output logic              smp_stb,
  output logic              smp_hs,
  output logic              smp_vs,
  output logic [DATA_W-1:0] smp_d
);

  localparam int BUS_W = DATA_W + 3;

  logic [BUS_W-1:0] pipe_q [STAGES];
  logic [BUS_W-1:0] pipe_d [STAGES];
  logic             pclk_prev_q;

  // Pixel clock, syncs and data all go through the same number of stages,
  // so they stay aligned with each other.
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign pipe_d[s] = {pix_clk, pix_hs, pix_vs, pix_d};
      end else begin : g_rest
        assign pipe_d[s] = pipe_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[s] <= '0;
        else        pipe_q[s] <= pipe_d[s];
      end
    end
  endgenerate

  logic pclk_cur;
  assign pclk_cur = pipe_q[STAGES-1][BUS_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pclk_prev_q <= 1'b0;
    else        pclk_prev_q <= pclk_cur;
  end

  always_comb begin
    if (cfg_pclk_rise) smp_stb = pclk_cur & ~pclk_prev_q;
    else               smp_stb = ~pclk_cur & pclk_prev_q;
  end

  assign smp_hs = pipe_q[STAGES-1][BUS_W-2];
  assign smp_vs = pipe_q[STAGES-1][BUS_W-3];
  assign smp_d  = pipe_q[STAGES-1][DATA_W-1:0];

endmodule

// File: rtl/cam_packer.sv
module cam_packer
  import cam_cap_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  pix_width_e        width,
  input  logic              stb,
  input  logic              hs_act,
  input  logic              vs_act,
  input  logic [DATA_W-1:0] d,
  output logic              done,
  output logic [WORD_W-1:0] word
);

  localparam int HALF_W  = WORD_W / 2;
  localparam int NARROW  = WORD_W / 8;
  localparam int CNT_W   = $clog2(NARROW);

  logic [WORD_W-1:0] acc_q, acc_n, ins;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DATA_W-1:0] sample;
  logic              take, clr, last;

  always_comb begin
    take   = en & stb & hs_act & vs_act;
    clr    = ~en | ~vs_act;
    sample = d & width_mask(width)[DATA_W-1:0];
    ins    = acc_q;
    if (width == PW_8) begin
      ins[int'(cnt_q)*8 +: 8] = sample[7:0];
      last = (cnt_q == CNT_W'(NARROW - 1));
    end else begin
      ins[int'(cnt_q[0])*HALF_W +: HALF_W] = {{(HALF_W-DATA_W){1'b0}}, sample};
      last = cnt_q[0];
    end
    done  = take & last;
    word  = ins;
    acc_n = acc_q;
    cnt_n = cnt_q;
    if (clr) begin
      acc_n = '0;
      cnt_n = '0;
    end else if (take) begin
      if (last) begin
        acc_n = '0;
        cnt_n = '0;
      end else begin
        acc_n = ins;
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_n;
      cnt_q <= cnt_n;
    end
  end

endmodule

// File: rtl/cam_word_reg.sv
module cam_word_reg #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              done,
  input  logic [WORD_W-1:0] word_in,
  input  logic              ack,
  output logic [WORD_W-1:0] q,
  output logic              req,
  output logic              ovr
);

  logic [WORD_W-1:0] q_n;
  logic              req_n, ovr_n, load;

  always_comb begin
    load  = done;
    q_n   = load ? word_in : q;
    if (done)     req_n = 1'b1;
    else if (ack) req_n = 1'b0;
    else          req_n = req;
    if (!en)                     ovr_n = 1'b0;
    else if (done & req & ~ack)  ovr_n = 1'b1;
    else                         ovr_n = ovr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      req <= 1'b0;
      ovr <= 1'b0;
    end else begin
      if (load) q <= q_n;
      req <= req_n;
      ovr <= ovr_n;
    end
  end

endmodule

// File: rtl/cam_capture_top.sv
module cam_capture_top
  import cam_cap_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int WORD_W = 32,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_pclk_rise,
  input  logic              cfg_hs_high,
  input  logic              cfg_vs_high,
  input  logic              pix_clk,
  input  logic              pix_hs,
  input  logic              pix_vs,
  input  logic [DATA_W-1:0] pix_d,
  output logic [WORD_W-1:0] word_q,
  output logic              word_req,
  input  logic              word_ack,
  output logic              overrun
);

  logic              smp_stb, smp_hs, smp_vs;
  logic [DATA_W-1:0] smp_d;
  logic              hs_act, vs_act, pk_done;
  logic [WORD_W-1:0] pk_word;

  cam_pin_sync #(.DATA_W(DATA_W), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cfg_pclk_rise(cfg_pclk_rise),
    .pix_clk(pix_clk), .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_d(pix_d),
    .smp_stb(smp_stb), .smp_hs(smp_hs), .smp_vs(smp_vs), .smp_d(smp_d)
  );

  assign hs_act = (smp_hs == cfg_hs_high);
  assign vs_act = (smp_vs == cfg_vs_high);

  cam_packer #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .width(pix_width_e'(cfg_width)),
    .stb(smp_stb), .hs_act(hs_act), .vs_act(vs_act), .d(smp_d),
    .done(pk_done), .word(pk_word)
  );

  cam_word_reg #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .done(pk_done), .word_in(pk_word),
    .ack(word_ack), .q(word_q), .req(word_req), .ovr(overrun)
  );

endmodule

// File: rtl/cam_capture_chk.sv
module cam_capture_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_en,
  input logic word_req,
  input logic word_ack,
  input logic overrun,
  input logic pk_done
);

  // R1
  no_req_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !word_req) |=> !word_req);

  // R1
  rise_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_req) |-> $past(cfg_en));

  // R10
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_req && !word_ack) |=> word_req);

  // R10
  done_raises_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pk_done |=> word_req);

  // R11
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pk_done && word_req && !word_ack && cfg_en) |=> overrun);

  // R11
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && cfg_en) |=> overrun);

endmodule

bind cam_capture_top cam_capture_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .word_req(word_req),
  .word_ack(word_ack), .overrun(overrun), .pk_done(pk_done)
);

// File: tb/tb_cam_capture_top.sv
`timescale 1ns/1ps
module tb_cam_capture_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_en, cfg_pclk_rise, cfg_hs_high, cfg_vs_high;
  logic [1:0]  cfg_width;
  logic        pix_clk, pix_hs, pix_vs;
  logic [13:0] pix_d;
  logic [31:0] word_q;
  logic        word_req, word_ack, overrun;

  int checks = 0;
  int errors = 0;
  bit auto_ack = 1'b1;
  bit done_flag = 1'b0;
  logic [31:0] exp_q [$];
  logic [31:0] m_acc;
  int          m_cnt;

  always #5 clk = ~clk;

  cam_capture_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_width(cfg_width),
    .cfg_pclk_rise(cfg_pclk_rise), .cfg_hs_high(cfg_hs_high), .cfg_vs_high(cfg_vs_high),
    .pix_clk(pix_clk), .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_d(pix_d),
    .word_q(word_q), .word_req(word_req), .word_ack(word_ack), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Reference model from the requirements, then drive one pixel period.
  task automatic pix(input logic [13:0] d, input bit hs, input bit vs);
    bit hs_a, vs_a;
    int nbits, slots;
    logic [15:0] s;
    hs_a = (hs == cfg_hs_high);
    vs_a = (vs == cfg_vs_high);
    if (!cfg_en || !vs_a) begin
      m_cnt = 0; m_acc = '0;
    end else if (hs_a) begin
      nbits = 8 + 2 * int'(cfg_width);
      s = 16'(d) & 16'((32'd1 << nbits) - 1);
      if (cfg_width == 2'b00) begin
        m_acc[m_cnt*8 +: 8] = s[7:0]; slots = 4;
      end else begin
        m_acc[m_cnt*16 +: 16] = s; slots = 2;
      end
      m_cnt++;
      if (m_cnt == slots) begin
        exp_q.push_back(m_acc); m_cnt = 0; m_acc = '0;
      end
    end
    pix_d = d; pix_hs = hs; pix_vs = vs;
    repeat (4) @(negedge clk);
    pix_clk = cfg_pclk_rise;
    repeat (4) @(negedge clk);
    pix_clk = ~cfg_pclk_rise;
  endtask

  task automatic drain(input string tag);
    repeat (12) @(negedge clk);
    chk(exp_q.size() == 0, tag, 32'(exp_q.size()), 32'd0);
  endtask

  // Monitor: pop expected words as the design presents them.
  initial begin
    logic [31:0] e;
    word_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (auto_ack && rst_n === 1'b1 && word_req === 1'b1) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected word", word_q, 32'h0);
        end else begin
          e = exp_q.pop_front();
          chk(word_q === e, "R2/R3/R4 packed word", word_q, e);
        end
        word_ack = 1'b1;
        @(negedge clk);
        word_ack = 1'b0;
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] e;
    rst_n = 1'b0; cfg_en = 1'b1; cfg_width = 2'b00; cfg_pclk_rise = 1'b1;
    cfg_hs_high = 1'b1; cfg_vs_high = 1'b1; pix_clk = 1'b0; pix_hs = 1'b0;
    pix_vs = 1'b0; pix_d = '0; m_acc = '0; m_cnt = 0;
    repeat (3) @(negedge clk);
    chk(word_req == 1'b0 && overrun == 1'b0 && word_q == 32'h0, "reset state", word_q, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 with R2: upper bits set, 8-bit mode
    for (int i = 0; i < 8; i++) pix(14'h3F00 | 14'(8'h11 * (i + 1)), 1, 1);
    pix(0, 0, 0);
    drain("R3 8-bit packing");

    // R4 with R2: 10, 12, 14 bits
    for (int w = 1; w < 4; w++) begin
      cfg_width = 2'(w);
      pix(14'h3FFF, 1, 1); pix(14'h2A5C, 1, 1);
      pix(14'h1234, 1, 1); pix(14'h0ABC, 1, 1);
      pix(0, 0, 0);
    end
    drain("R4 wide packing");

    // R6: samples with line sync inactive are skipped
    cfg_width = 2'b00;
    pix(14'h0A1, 1, 1); pix(14'h0EE, 0, 1); pix(14'h0B2, 1, 1);
    pix(14'h0EF, 0, 1); pix(14'h0C3, 1, 1); pix(14'h0D4, 1, 1);
    pix(0, 0, 0);
    drain("R6 line gating");

    // R7: partial word dropped at frame end
    pix(14'h055, 1, 1); pix(14'h066, 1, 1); pix(14'h077, 1, 1);
    pix(14'h099, 1, 0);
    for (int i = 0; i < 4; i++) pix(14'(8'h21 + i), 1, 1);
    pix(0, 0, 0);
    drain("R7 frame gating and discard");

    // R1: capture disabled
    cfg_en = 1'b0;
    for (int i = 0; i < 4; i++) pix(14'h0F0, 1, 1);
    repeat (8) @(negedge clk);
    chk(word_req == 1'b0, "R1 no request while disabled", 32'(word_req), 32'd0);
    cfg_en = 1'b1;
    pix(0, 0, 0);
    drain("R1 enable gating");

    // R5: falling-edge capture
    cfg_pclk_rise = 1'b0; pix_clk = 1'b1;
    repeat (6) @(negedge clk);
    cfg_width = 2'b10;
    pix(14'h0321, 1, 1); pix(14'h0FED, 1, 1);
    pix(0, 0, 0);
    drain("R5 falling edge");
    cfg_pclk_rise = 1'b1; pix_clk = 1'b0;
    repeat (6) @(negedge clk);

    // R8: active-low syncs
    cfg_hs_high = 1'b0; cfg_vs_high = 1'b0; cfg_width = 2'b01;
    pix(14'h155, 1, 1); pix(14'h2AA, 0, 0); pix(14'h111, 1, 0);
    pix(14'h0CC, 0, 0); pix(14'h3FF, 1, 1);
    drain("R8 active-low syncs");
    cfg_hs_high = 1'b1; cfg_vs_high = 1'b1;
    pix(0, 0, 0);

    // R9: both syncs switching on the same edge
    cfg_width = 2'b01;
    pix(14'h101, 1, 1); pix(14'h202, 1, 1);
    pix(14'h3EE, 0, 0);
    pix(14'h0AB, 1, 1); pix(14'h0CD, 1, 1);
    pix(0, 0, 0);
    drain("R9 simultaneous sync change");

    // R11: overrun, second word replaces first
    auto_ack = 1'b0;
    cfg_width = 2'b00;
    for (int i = 0; i < 8; i++) pix(14'(8'h40 + i), 1, 1);
    pix(0, 0, 0);
    repeat (8) @(negedge clk);
    void'(exp_q.pop_front());
    e = exp_q.pop_front();
    chk(word_req == 1'b1, "R10 request held without ack", 32'(word_req), 32'd1);
    chk(overrun == 1'b1, "R11 overrun set", 32'(overrun), 32'd1);
    chk(word_q == e, "R11 newest word kept", word_q, e);
    word_ack = 1'b1; @(negedge clk); word_ack = 1'b0;
    @(negedge clk);
    chk(word_req == 1'b0, "R10 request dropped after ack", 32'(word_req), 32'd0);
    chk(overrun == 1'b1, "R11 overrun sticky", 32'(overrun), 32'd1);
    cfg_en = 1'b0; repeat (2) @(negedge clk);
    chk(overrun == 1'b0, "R1 disable clears overrun", 32'(overrun), 32'd0);
    cfg_en = 1'b1; auto_ack = 1'b1;

    done_flag = 1'b1;
    summary();
  end

endmodule